// File: doc/BRIEF.md
# Radix-4 Carry-Save Mantissa Divider

This block divides one normalized mantissa by another. It produces one quotient digit per clock in radix 4, and each digit is taken from the redundant set -2, -1, 0, +1, +2. The partial remainder is never resolved into one number inside the loop. It stays as a sum word and a carry word, and a 3:2 carry-save adder updates both words on every step. The subtracted multiple of the divisor is made only by shifting, inverting or clearing. A digit selector reads a nine-bit estimate taken from the top of both words. It compares that estimate against four thresholds, which are computed once from the leading five divisor bits when the operation starts.

Each operand is an unsigned `MANT_W`-bit mantissa with its most significant bit set, so its value lies in [1,2). There is one integer bit and `MANT_W-1` fraction bits. A `start` pulse while the block is idle loads the operands. The block then emits `ITERS` digits, most significant first, one on each cycle in which `q_valid` is high. After that it raises `done` for one cycle and holds the final redundant remainder. The digit stream has no back-pressure: a consumer must accept a digit in every cycle where `q_valid` is high. `start` is a plain control pin. Exponent handling, rounding and conversion of the digits to a binary quotient are left to neighbouring logic.

Top module: `srt4_divider`

## Requirements
- R1: When `start` is high in a cycle where `busy` is low, the next cycle shows `busy` high, `rem_carry` all zeros and `rem_sum` equal to the dividend, zero-extended. The remainder words are two's complement with `MANT_W-1` fraction bits and five integer bits.
- R2: One operation emits exactly `ITERS` digits, one in each consecutive cycle with `q_valid` high. `q_digit` is a 3-bit two's-complement value and is always one of -2, -1, 0, +1, +2.
- R3: At every step boundary the true remainder P = `rem_sum` + `rem_carry` (taken modulo 2^RW and read as signed) satisfies 3·|P| ≤ 8·D, where D is the divisor.
- R4: Let the emitted digits q0..q(ITERS-1) have weights 4^(ITERS-1-j), giving the integer Q. Then X·4^ITERS = 4·D·Q + P_final holds exactly in units of 2^-(MANT_W-1).
- R5: Q equals floor(X·4^(ITERS-1)/D) or that value plus one. This includes the pair 0x800BF6 / 0xBFFFFC.
- R6: `done` is high for exactly one cycle, in the cycle right after the last digit. In that cycle `busy` and `q_valid` are low, and the final remainder stays on `rem_sum`/`rem_carry` until the next start.
- R7: A `start` pulse while `busy` is high is ignored. The running operation finishes with the digits and remainder of its original operands.
- R8: The latched divisor does not change while an operation runs.
- R9: After reset `busy`, `q_valid` and `done` are low and both remainder words are zero.
- R10: A `start` in the same cycle as `done` is accepted, so the next operation begins on the following cycle without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| dividend | input | MANT_W | Dividend mantissa in [1,2) |
| divisor | input | MANT_W | Divisor mantissa in [1,2) |
| busy | output | 1 | Operation in progress |
| q_valid | output | 1 | `q_digit` carries a digit this cycle |
| q_digit | output | 3 | Signed quotient digit |
| done | output | 1 | One-cycle pulse after the last digit |
| rem_sum | output | MANT_W+4 | Remainder sum word |
| rem_carry | output | MANT_W+4 | Remainder carry word |

## Verification
Two events can fall in the same cycle: the `done` pulse of one operation and the acceptance of a new `start`. The bench provokes this by raising `start` in the very cycle where `done` is seen. It judges the overlap in two ways. The first digit of the new operation must appear on the next cycle with the remainder reloaded from the new dividend. The earlier operation's digits and final remainder must still satisfy the reconstruction identity. A second overlap is a `start` that arrives mid-run. The bench judges it by checking that the finished result matches the first operand pair and not the intruding one.

// File: rtl/srt4_pkg.sv
package srt4_pkg;
  localparam int EST_INT  = 5;
  localparam int EST_FRAC = 4;
  localparam int EST_W    = EST_INT + EST_FRAC;
  localparam int DHAT_W   = 1 + EST_FRAC;

  typedef logic signed [2:0] digit_t;

  typedef struct packed {
    logic signed [EST_W-1:0] to_p2;
    logic signed [EST_W-1:0] to_p1;
    logic signed [EST_W-1:0] to_z;
    logic signed [EST_W-1:0] to_m1;
  } thr_t;
endpackage

// File: rtl/srt4_thresholds.sv
module srt4_thresholds
  import srt4_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic [MANT_W-1:0] divisor,
  output thr_t              thr
);
  logic [EST_W-1:0] dh, up2, up1, dn1, dn2;

  always_comb begin
    dh  = {{(EST_W-DHAT_W){1'b0}}, divisor[MANT_W-1 -: DHAT_W]};
    // ceil(4(dh+1)/3), ceil((dh+1)/3), floor(2dh/3), floor(5dh/3)
    up2 = (EST_W'(4) * (dh + EST_W'(1)) + EST_W'(2)) / EST_W'(3);
    up1 = (dh + EST_W'(3)) / EST_W'(3);
    dn1 = (EST_W'(2) * dh) / EST_W'(3);
    dn2 = (EST_W'(5) * dh) / EST_W'(3);
    thr.to_p2 = $signed(up2);
    thr.to_p1 = $signed(up1);
    thr.to_z  = $signed(EST_W'(0) - dn1);
    thr.to_m1 = $signed(EST_W'(0) - dn2);
  end
endmodule

// File: rtl/srt4_digit_sel.sv
module srt4_digit_sel
  import srt4_pkg::*;
#(
  parameter int RW = 28
) (
  input  logic [RW-1:0] rsum,
  input  logic [RW-1:0] rcarry,
  input  thr_t          thr,
  output digit_t        q
);
  logic signed [EST_W-1:0] est;

  always_comb begin
    est = $signed(rsum[RW-1 -: EST_W] + rcarry[RW-1 -: EST_W]);
    if (est >= thr.to_p2)      q = 3'sd2;
    else if (est >= thr.to_p1) q = 3'sd1;
    else if (est >= thr.to_z)  q = 3'sd0;
    else if (est >= thr.to_m1) q = -3'sd1;
    else                       q = -3'sd2;
  end
endmodule

// File: rtl/srt4_multiple.sv
module srt4_multiple
  import srt4_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int RW     = 28
) (
  input  logic [MANT_W-1:0] divisor,
  input  digit_t            q,
  output logic [RW-1:0]     mult,
  output logic              inj
);
  logic [RW-1:0] d1, d2;

  always_comb begin
    d1  = {{(RW-MANT_W){1'b0}}, divisor};
    d2  = d1 << 1;
    inj = 1'b0;
    unique case (q)
      3'sd1:   begin mult = ~d1; inj = 1'b1; end
      3'sd2:   begin mult = ~d2; inj = 1'b1; end
      -3'sd1:  mult = d1;
      -3'sd2:  mult = d2;
      default: mult = '0;
    endcase
  end
endmodule

// File: rtl/srt4_csa.sv
module srt4_csa #(
  parameter int RW = 28
) (
  input  logic [RW-1:0] s_in,
  input  logic [RW-1:0] c_in,
  input  logic [RW-1:0] m_in,
  input  logic          inj,
  output logic [RW-1:0] s_out,
  output logic [RW-1:0] c_out
);
  logic [RW-1:0] bsum, bcy, cvec;

  for (genvar i = 0; i < RW; i++) begin : g_bit
    assign bsum[i] = s_in[i] ^ c_in[i] ^ m_in[i];
    assign bcy[i]  = (s_in[i] & c_in[i]) | (s_in[i] & m_in[i]) | (c_in[i] & m_in[i]);
  end

  assign cvec  = {bcy[RW-2:0], inj};
  assign s_out = {bsum[RW-3:0], 2'b00};
  assign c_out = {cvec[RW-3:0], 2'b00};
endmodule

// File: rtl/srt4_divider.sv
module srt4_divider
  import srt4_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int ITERS  = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [MANT_W-1:0]      dividend,
  input  logic [MANT_W-1:0]      divisor,
  output logic                   busy,
  output logic                   q_valid,
  output logic signed [2:0]      q_digit,
  output logic                   done,
  output logic [MANT_W+3:0]      rem_sum,
  output logic [MANT_W+3:0]      rem_carry
);
  localparam int FRAC  = MANT_W - 1;
  localparam int RW    = FRAC + EST_INT;
  localparam int CNT_W = $clog2(ITERS + 1);

  logic [RW-1:0]     s_q, c_q, s_nx, c_nx, mult;
  logic [MANT_W-1:0] d_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q, inj;
  thr_t              thr_q, thr_new;
  digit_t            qd;

  srt4_thresholds #(.MANT_W(MANT_W)) u_thr (
    .divisor(divisor), .thr(thr_new)
  );

  srt4_digit_sel #(.RW(RW)) u_sel (
    .rsum(s_q), .rcarry(c_q), .thr(thr_q), .q(qd)
  );

  srt4_multiple #(.MANT_W(MANT_W), .RW(RW)) u_mul (
    .divisor(d_q), .q(qd), .mult(mult), .inj(inj)
  );

  srt4_csa #(.RW(RW)) u_csa (
    .s_in(s_q), .c_in(c_q), .m_in(mult), .inj(inj),
    .s_out(s_nx), .c_out(c_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q    <= '0;
      c_q    <= '0;
      d_q    <= '0;
      thr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          s_q    <= {{(RW-MANT_W){1'b0}}, dividend};
          c_q    <= '0;
          d_q    <= divisor;
          thr_q  <= thr_new;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        s_q   <= s_nx;
        c_q   <= c_nx;
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(ITERS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign q_valid   = busy_q;
  assign q_digit   = qd;
  assign done      = done_q;
  assign rem_sum   = s_q;
  assign rem_carry = c_q;
endmodule

// File: rtl/srt4_divider_chk.sv
module srt4_divider_chk #(
  parameter int MANT_W = 24,
  parameter int ITERS  = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [MANT_W-1:0]     dividend,
  input logic                  busy,
  input logic                  q_valid,
  input logic signed [2:0]     q_digit,
  input logic                  done,
  input logic [MANT_W+3:0]     rem_sum,
  input logic [MANT_W+3:0]     rem_carry,
  input logic [MANT_W-1:0]     div_q
);
  localparam int RW    = MANT_W + 4;
  localparam int CNT_W = $clog2(ITERS + 2);

  logic [RW-1:0]        ptot;
  logic [RW-1:0]        pmag;
  logic [RW+3:0]        lhs, rhs;
  logic [CNT_W-1:0]     seen;

  always_comb begin
    ptot = rem_sum + rem_carry;
    pmag = ptot[RW-1] ? (~ptot + RW'(1)) : ptot;
    lhs  = (RW+4)'(pmag) * (RW+4)'(3);
    rhs  = (RW+4)'(div_q) * (RW+4)'(8);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (start && !busy) seen <= '0;
    else if (q_valid) seen <= seen + CNT_W'(1);
  end

  // R1
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && rem_carry == '0 &&
                          rem_sum == {4'b0000, $past(dividend)}));

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (q_digit >= -3'sd2 && q_digit <= 3'sd2));

  // R2
  digit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seen == CNT_W'(ITERS)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |-> (lhs <= rhs));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !q_valid));

  // R8
  divisor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(div_q));
endmodule

bind srt4_divider srt4_divider_chk #(.MANT_W(MANT_W), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
  .busy(busy), .q_valid(q_valid), .q_digit(q_digit), .done(done),
  .rem_sum(rem_sum), .rem_carry(rem_carry), .div_q(d_q)
);

// File: tb/tb_srt4_divider.sv
module tb_srt4_divider;
  localparam int MANT_W = 24;
  localparam int ITERS  = 13;
  localparam int RW     = MANT_W + 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [MANT_W-1:0]     dividend = '0;
  logic [MANT_W-1:0]     divisor = '0;
  logic                  busy, q_valid, done;
  logic signed [2:0]     q_digit;
  logic [RW-1:0]         rem_sum, rem_carry;

  int n_run = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;

  srt4_divider #(.MANT_W(MANT_W), .ITERS(ITERS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .q_valid(q_valid), .q_digit(q_digit),
    .done(done), .rem_sum(rem_sum), .rem_carry(rem_carry)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint signed_rem(input logic [RW-1:0] s, input logic [RW-1:0] c);
    logic [RW-1:0] t;
    t = s + c;
    return longint'($signed(t));
  endfunction

  function automatic longint ref_quot(input longint x, input longint d);
    return (x <<< (2 * (ITERS - 1))) / d;
  endfunction

  task automatic launch(input logic [MANT_W-1:0] x, input logic [MANT_W-1:0] d);
    dividend = x;
    divisor  = d;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  // Called at the negedge right after launch; returns at negedge of the done cycle.
  task automatic collect(input logic [MANT_W-1:0] x, input logic [MANT_W-1:0] d,
                         input bit intrude);
    longint q = 0;
    longint p;
    int cnt = 0;
    longint xl = longint'(x);
    longint dl = longint'(d);
    longint r;
    // R1
    chk(busy == 1'b1, "R1 busy after start", longint'(busy), 1);
    chk(rem_sum == {4'b0000, x} && rem_carry == '0, "R1 remainder load",
        longint'(rem_sum), xl);
    while (!done && !timed_out) begin
      if (q_valid) begin
        q = q * 4 + longint'(q_digit);
        cnt++;
        if (intrude && cnt == 5) begin
          dividend = 24'hC00000;
          divisor  = 24'h800001;
          start    = 1'b1;
        end
        if (intrude && cnt == 6) start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    // R2
    chk(cnt == ITERS, "R2 digit count", cnt, ITERS);
    // R6
    chk(!busy && !q_valid, "R6 idle during done", longint'(busy), 0);
    p = signed_rem(rem_sum, rem_carry);
    // R4 (R7 when intruded)
    chk((xl <<< (2 * ITERS)) == 4 * dl * q + p,
        intrude ? "R7 identity after ignored start" : "R4 identity",
        4 * dl * q + p, xl <<< (2 * ITERS));
    // R3
    chk(3 * (p < 0 ? -p : p) <= 8 * dl, "R3 final remainder bound", p, dl);
    // R5
    r = ref_quot(xl, dl);
    chk(q == r || q == r + 1, "R5 quotient vs reference", q, r);
  endtask

  task automatic one_div(input logic [MANT_W-1:0] x, input logic [MANT_W-1:0] d,
                         input bit intrude);
    logic [RW-1:0] s_keep, c_keep;
    @(negedge clk);
    launch(x, d);
    collect(x, d, intrude);
    s_keep = rem_sum;
    c_keep = rem_carry;
    @(negedge clk);
    // R6
    chk(done == 1'b0, "R6 done single cycle", longint'(done), 0);
    chk(rem_sum == s_keep && rem_carry == c_keep, "R6 remainder held",
        longint'(rem_sum), longint'(s_keep));
  endtask

  initial begin
    #1500000;
    timed_out = 1'b1;
  end

  initial begin
    // R9
    repeat (3) @(negedge clk);
    chk(busy == 0 && q_valid == 0 && done == 0, "R9 reset control", longint'(busy), 0);
    chk(rem_sum == '0 && rem_carry == '0, "R9 reset remainder", longint'(rem_sum), 0);
    rst_n = 1'b1;

    one_div(24'h800BF6, 24'hBFFFFC, 1'b0);
    one_div(24'h800000, 24'h800000, 1'b0);
    one_div(24'hFFFFFF, 24'h800000, 1'b0);
    one_div(24'h800000, 24'hFFFFFF, 1'b0);
    one_div(24'hFFFFFF, 24'hFFFFFF, 1'b0);
    one_div(24'hC00000, 24'h800001, 1'b0);
    one_div(24'hAAAAAA, 24'hBFFFFF, 1'b0);

    // R7: start mid-run is ignored
    one_div(24'h9ABCDE, 24'hF0F0F1, 1'b1);

    // R10: start in the same cycle as done
    @(negedge clk);
    launch(24'hD00001, 24'h8F0000);
    collect(24'hD00001, 24'h8F0000, 1'b0);
    launch(24'h800BF6, 24'hA7FFF8);
    chk(q_valid == 1'b1, "R10 back-to-back first digit", longint'(q_valid), 1);
    collect(24'h800BF6, 24'hA7FFF8, 1'b0);
    @(negedge clk);

    void'($urandom(32'd1994));
    for (int i = 0; i < 60 && !timed_out; i++) begin
      logic [MANT_W-1:0] rx, rd;
      rx = {1'b1, 23'($urandom)};
      rd = {1'b1, 23'($urandom)};
      if (i % 4 == 0) rd[22:15] = 8'hFF;
      one_div(rx, rd, 1'b0);
    end

    if (timed_out) chk(1'b0, "watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge timed_out) begin
    chk(1'b0, "watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule